// File: doc/BRIEF.md
# Chained DMA source tag engine

This block is the memory-side half of a chained DMA channel. Software programs a data address, a quadword count, a tag address and a mode, then raises a start level. In normal mode the engine copies the given number of 128-bit quadwords from memory into an outbound 32-bit word FIFO. In chain mode it instead walks a linked list of 128-bit tags kept in memory. Each tag supplies the next quadword count. It also tells the engine where that data sits and where the following tag lives.

Quadwords are read one at a time through a simple request/valid memory port. Each quadword is split into four FIFO words, lowest word first. Data moves in bursts sized by the FIFO space that is free. A tag can optionally be copied into the stream ahead of its data, and a tag can optionally end the chain early. When the work is finished the engine pulses a completion interrupt. A tag with an unknown type stops the chain and raises an error flag. Dropping the start level aborts the transfer silently.

Top module: `sdma_chain_src`

## Requirements
- R1: After reset, `busy`, `done_irq`, `tag_err`, `fifo_push` and `mem_req` are all 0, and while `busy` is 0 neither `fifo_push` nor `mem_req` is asserted.
- R2: In normal mode (`cfg_chain`=0), a rising edge of `cfg_start` moves `cfg_qwc` quadwords starting at `cfg_madr`, at addresses that climb by 16. Each quadword becomes four FIFO words: bits 31:0 first, bits 127:96 last. The engine then gives a single one-cycle `done_irq` pulse and `busy` falls. A count of 0 completes at once with the pulse and no data.
- R3: A data burst starts only when `fifo_free` is at least 4. It moves min(remaining count, `fifo_free`/4) quadwords and then re-evaluates. No word is pushed while `fifo_free` is 0, and the engine stalls with `busy` high while space is lacking.
- R4: Tag layout: count in bits 15:0, type in bits 30:28, interrupt bit in bit 31, address in bits 62:32. For a count tag (type 1), data starts at tag address + 16 and the next tag is at tag address + 16 + 16×count.
- R5: For a next tag (type 2), data starts at tag address + 16 and the next tag is at the tag's address field.
- R6: For a reference tag (type 3) or a reference-stall tag (type 4), data is read from the tag's address field and the next tag is at tag address + 16.
- R7: A reference-end tag (type 0) behaves as type 3, and an end tag (type 7) behaves as type 1. Both end the chain once their data is moved, followed by one `done_irq` pulse.
- R8: With `cfg_tag_fwd`=1, tag bits 95:64 and then bits 127:96 are pushed into the FIFO before that tag's data.
- R9: With `cfg_tag_irq_en`=1, a tag whose bit 31 is set ends the chain after its data. With `cfg_tag_irq_en`=0 that bit has no effect and the chain continues.
- R10: A tag of type 5 or 6 sets `tag_err`, which stays set until the next start. `busy` drops, no `done_irq` pulse is given and no data from that tag is pushed.
- R11: Lowering `cfg_start` while `busy` is high makes `busy` 0 on the next cycle. No `done_irq` follows, and no further pushes or memory requests occur.
- R12: `mem_req` is a one-cycle pulse. Only one read is outstanding at a time, so there is exactly one request for every tag and every quadword read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start level; a rising edge starts, a falling edge aborts |
| cfg_chain | input | 1 | 0 normal mode, 1 chain mode |
| cfg_tag_fwd | input | 1 | Copy the upper half of each tag into the FIFO |
| cfg_tag_irq_en | input | 1 | Let the tag interrupt bit end the chain |
| cfg_madr | input | ADDR_W | Initial data address |
| cfg_tadr | input | ADDR_W | Initial tag address |
| cfg_qwc | input | CNT_W | Initial quadword count |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read quadword |
| fifo_free | input | FREE_W | Free words in the outbound FIFO |
| fifo_push | output | 1 | Push one word |
| fifo_wdata | output | 32 | Word pushed |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| tag_err | output | 1 | Unknown tag type seen |

## Verification
On every cycle the assertions check the following. No push happens while the FIFO reports no room. The memory request and the completion pulse each last a single cycle. An idle engine drives neither port. An abort clears `busy` at once. A completion pulse never coincides with the error flag. The routing of each tag type, the stream order with forwarded tags, burst sizing under back-pressure and the early end on tag interrupts are cycle-independent data properties. Only the bench's scenarios show these, by comparing the whole logged word stream and the request count against values built from the tag contents.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int QW_BITS   = 128;
    localparam int WORD_BITS = 32;
    localparam int TAG_AW    = 31;

    typedef enum logic [2:0] {
        TID_REFE = 3'd0,
        TID_CNT  = 3'd1,
        TID_NEXT = 3'd2,
        TID_REF  = 3'd3,
        TID_REFS = 3'd4,
        TID_END  = 3'd7
    } tag_id_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DREQ,
        ST_DWAIT,
        ST_DPUSH,
        ST_TREQ,
        ST_TWAIT,
        ST_TPUSH
    } eng_state_e;

    // Chain-end contribution of a tag type alone.
    function automatic logic id_ends_chain(logic [2:0] id);
        return (id == TID_REFE) || (id == TID_END);
    endfunction

    // Types 5 and 6 are not defined.
    function automatic logic id_known(logic [2:0] id);
        return (id != 3'd5) && (id != 3'd6);
    endfunction

endpackage

// File: rtl/sdma_tag_decode.sv
module sdma_tag_decode
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [2:0]        tag_id,
    input  logic [CNT_W-1:0]  tag_qwc,
    input  logic [TAG_AW-1:0] tag_addr,
    input  logic [ADDR_W-1:0] cur_tadr,
    output logic              ok,
    output logic              ends,
    output logic [ADDR_W-1:0] madr_n,
    output logic [ADDR_W-1:0] tadr_n
);
    logic [ADDR_W-1:0] after_tag;
    logic [ADDR_W-1:0] field_addr;
    logic [ADDR_W-1:0] data_bytes;

    always_comb begin
        after_tag  = cur_tadr + ADDR_W'(16);
        field_addr = ADDR_W'(tag_addr);
        data_bytes = ADDR_W'(tag_qwc) << 4;
        ok         = id_known(tag_id);
        ends       = id_ends_chain(tag_id);
        madr_n     = after_tag;
        tadr_n     = after_tag + data_bytes;
        case (tag_id)
            TID_NEXT: begin
                madr_n = after_tag;
                tadr_n = field_addr;
            end
            TID_REF, TID_REFS, TID_REFE: begin
                madr_n = field_addr;
                tadr_n = after_tag;
            end
            default: begin
                madr_n = after_tag;
                tadr_n = after_tag + data_bytes;
            end
        endcase
    end
endmodule

// File: rtl/sdma_burst_calc.sv
module sdma_burst_calc #(
    parameter int CNT_W  = 16,
    parameter int FREE_W = 8
) (
    input  logic [CNT_W-1:0]  qwc,
    input  logic [FREE_W-1:0] free_words,
    output logic              room,
    output logic [CNT_W-1:0]  burst
);
    localparam int SLOT_W = FREE_W - 2;

    logic [SLOT_W-1:0] slots;

    always_comb begin
        slots = free_words[FREE_W-1:2];
        room  = slots != '0;
        if (CNT_W'(slots) < qwc) burst = CNT_W'(slots);
        else                     burst = qwc;
    end
endmodule

// File: rtl/sdma_word_sel.sv
module sdma_word_sel #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic [WORDS*WORD_W-1:0] qbuf,
    input  logic [IDX_W-1:0]        idx,
    output logic [WORD_W-1:0]       word
);
    logic [WORD_W-1:0] lanes [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        assign lanes[g] = qbuf[g*WORD_W +: WORD_W];
    end

    assign word = lanes[idx];
endmodule

// File: rtl/sdma_chain_src.sv
module sdma_chain_src
    import sdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int FREE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_start,
    input  logic                 cfg_chain,
    input  logic                 cfg_tag_fwd,
    input  logic                 cfg_tag_irq_en,
    input  logic [ADDR_W-1:0]    cfg_madr,
    input  logic [ADDR_W-1:0]    cfg_tadr,
    input  logic [CNT_W-1:0]     cfg_qwc,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_rvalid,
    input  logic [QW_BITS-1:0]   mem_rdata,
    input  logic [FREE_W-1:0]    fifo_free,
    output logic                 fifo_push,
    output logic [WORD_BITS-1:0] fifo_wdata,
    output logic                 busy,
    output logic                 done_irq,
    output logic                 tag_err
);
    localparam int WPQ   = QW_BITS / WORD_BITS;
    localparam int IDX_W = $clog2(WPQ);

    eng_state_e          state;
    logic                start_q;
    logic                start_rise;
    logic [ADDR_W-1:0]   madr;
    logic [ADDR_W-1:0]   tadr;
    logic [CNT_W-1:0]    qwc;
    logic [CNT_W-1:0]    burst_left;
    logic                chain_q;
    logic                fwd_q;
    logic                irqen_q;
    logic                end_f;
    logic [QW_BITS-1:0]  qbuf;
    logic [IDX_W-1:0]    widx;

    logic                dec_ok;
    logic                dec_end;
    logic [ADDR_W-1:0]   dec_madr;
    logic [ADDR_W-1:0]   dec_tadr;
    logic                room;
    logic [CNT_W-1:0]    burst_n;

    assign start_rise = cfg_start && !start_q;

    sdma_tag_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .tag_id   (mem_rdata[30:28]),
        .tag_qwc  (mem_rdata[CNT_W-1:0]),
        .tag_addr (mem_rdata[62:32]),
        .cur_tadr (tadr),
        .ok       (dec_ok),
        .ends     (dec_end),
        .madr_n   (dec_madr),
        .tadr_n   (dec_tadr)
    );

    sdma_burst_calc #(.CNT_W(CNT_W), .FREE_W(FREE_W)) u_burst (
        .qwc        (qwc),
        .free_words (fifo_free),
        .room       (room),
        .burst      (burst_n)
    );

    sdma_word_sel #(.WORDS(WPQ), .WORD_W(WORD_BITS)) u_sel (
        .qbuf (qbuf),
        .idx  (widx),
        .word (fifo_wdata)
    );

    assign busy      = state != ST_IDLE;
    assign mem_req   = (state == ST_DREQ) || (state == ST_TREQ);
    assign mem_addr  = (state == ST_TREQ) ? tadr : madr;
    assign fifo_push = (state == ST_DPUSH) ||
                       ((state == ST_TPUSH) && (fifo_free != '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            start_q    <= 1'b0;
            madr       <= '0;
            tadr       <= '0;
            qwc        <= '0;
            burst_left <= '0;
            chain_q    <= 1'b0;
            fwd_q      <= 1'b0;
            irqen_q    <= 1'b0;
            end_f      <= 1'b0;
            qbuf       <= '0;
            widx       <= '0;
            done_irq   <= 1'b0;
            tag_err    <= 1'b0;
        end else begin
            start_q  <= cfg_start;
            done_irq <= 1'b0;
            if (state == ST_IDLE) begin
                if (start_rise) begin
                    madr    <= cfg_madr;
                    tadr    <= cfg_tadr;
                    qwc     <= cfg_qwc;
                    chain_q <= cfg_chain;
                    fwd_q   <= cfg_tag_fwd;
                    irqen_q <= cfg_tag_irq_en;
                    end_f   <= 1'b0;
                    tag_err <= 1'b0;
                    state   <= ST_CHECK;
                end
            end else if (!cfg_start) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_CHECK: begin
                        if (qwc == '0) begin
                            if (!chain_q || end_f) begin
                                done_irq <= 1'b1;
                                state    <= ST_IDLE;
                            end else begin
                                state <= ST_TREQ;
                            end
                        end else if (room) begin
                            burst_left <= burst_n;
                            state      <= ST_DREQ;
                        end
                    end
                    ST_DREQ: state <= ST_DWAIT;
                    ST_DWAIT: begin
                        if (mem_rvalid) begin
                            qbuf  <= mem_rdata;
                            widx  <= '0;
                            state <= ST_DPUSH;
                        end
                    end
                    ST_DPUSH: begin
                        widx <= widx + 1'b1;
                        if (widx == IDX_W'(WPQ - 1)) begin
                            madr       <= madr + ADDR_W'(16);
                            qwc        <= qwc - 1'b1;
                            burst_left <= burst_left - 1'b1;
                            state      <= (burst_left == CNT_W'(1)) ? ST_CHECK : ST_DREQ;
                        end
                    end
                    ST_TREQ: state <= ST_TWAIT;
                    ST_TWAIT: begin
                        if (mem_rvalid) begin
                            qbuf <= mem_rdata;
                            if (!dec_ok) begin
                                tag_err <= 1'b1;
                                state   <= ST_IDLE;
                            end else begin
                                madr  <= dec_madr;
                                tadr  <= dec_tadr;
                                qwc   <= mem_rdata[CNT_W-1:0];
                                end_f <= end_f || dec_end || (irqen_q && mem_rdata[31]);
                                widx  <= IDX_W'(2);
                                state <= fwd_q ? ST_TPUSH : ST_CHECK;
                            end
                        end
                    end
                    ST_TPUSH: begin
                        if (fifo_free != '0) begin
                            widx <= widx + 1'b1;
                            if (widx == IDX_W'(WPQ - 1)) state <= ST_CHECK;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdma_chain_src_chk.sv
module sdma_chain_src_chk #(
    parameter int FREE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_start,
    input logic              busy,
    input logic              done_irq,
    input logic              tag_err,
    input logic              fifo_push,
    input logic [FREE_W-1:0] fifo_free,
    input logic              mem_req
);
    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> (fifo_free != '0)); // R3

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R12

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fifo_push && !mem_req)); // R1

    AST_IRQ_NOT_ERR: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> !tag_err); // R10

    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (rst)
        ($fell(cfg_start) && busy) |=> (!busy && !done_irq)); // R11
endmodule

bind sdma_chain_src sdma_chain_src_chk #(.FREE_W(FREE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_start (cfg_start),
    .busy      (busy),
    .done_irq  (done_irq),
    .tag_err   (tag_err),
    .fifo_push (fifo_push),
    .fifo_free (fifo_free),
    .mem_req   (mem_req)
);

// File: tb/sdma_chain_src_bench.sv
module sdma_chain_src_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int CW   = 16;
    localparam int FW   = 8;
    localparam int CAP  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_start = 0, cfg_chain = 0, cfg_tag_fwd = 0, cfg_tag_irq_en = 0;
    logic [AW-1:0] cfg_madr = '0, cfg_tadr = '0;
    logic [CW-1:0] cfg_qwc = '0;
    logic mem_req, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [127:0] mem_rdata;
    logic [FW-1:0] fifo_free;
    logic fifo_push, busy, done_irq, tag_err;
    logic [31:0] fifo_wdata;

    logic [127:0] mem [0:63];
    int level = 0;
    logic drain = 1'b1;
    logic flush = 1'b0;
    logic [31:0] wlog [0:255];
    logic [31:0] exp_w [0:255];
    int nlog = 0, nirq = 0, nreq = 0, nexp = 0;
    int nchecks = 0, nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdma_chain_src #(.ADDR_W(AW), .CNT_W(CW), .FREE_W(FW)) u_sdma_chain_src (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_chain(cfg_chain),
        .cfg_tag_fwd(cfg_tag_fwd), .cfg_tag_irq_en(cfg_tag_irq_en),
        .cfg_madr(cfg_madr), .cfg_tadr(cfg_tadr), .cfg_qwc(cfg_qwc),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .fifo_free(fifo_free), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .busy(busy), .done_irq(done_irq), .tag_err(tag_err)
    );

    assign fifo_free = FW'(CAP - level);

    function automatic logic [31:0] mw(int k, int j);
        return 32'h5000_0000 | (k << 8) | j;
    endfunction

    function automatic logic [63:0] mk_tag(int id, bit irq, int qwc, int addr);
        logic [63:0] t;
        t = '0;
        t[15:0]  = qwc[15:0];
        t[30:28] = id[2:0];
        t[31]    = irq;
        t[62:32] = addr[30:0];
        return t;
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[9:4]];
        if (flush) level <= 0;
        else level <= level + (fifo_push ? 1 : 0) - ((drain && level > 0) ? 1 : 0);
    end

    always @(posedge clk) begin
        if (fifo_push) begin
            if (nlog < 256) wlog[nlog] = fifo_wdata;
            nlog = nlog + 1;
        end
        if (done_irq) nirq = nirq + 1;
        if (mem_req) nreq = nreq + 1;
    end

    task automatic check(string req, string what, int act, int expv);
        nchecks++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic exp_qw(int k);
        for (int j = 0; j < 4; j++) begin
            exp_w[nexp] = mw(k, j);
            nexp++;
        end
    endtask

    task automatic exp_tagfwd(int k);
        exp_w[nexp] = mw(k, 2); nexp++;
        exp_w[nexp] = mw(k, 3); nexp++;
    endtask

    task automatic check_log(string req);
        check(req, "word count", nlog, nexp);
        for (int i = 0; i < nexp && i < nlog; i++)
            check(req, "stream word", wlog[i], exp_w[i]);
    endtask

    task automatic clear_run();
        @(negedge clk);
        cfg_start = 0;
        drain = 1;
        flush = 1;
        @(negedge clk);
        flush = 0;
        nlog = 0; nirq = 0; nreq = 0; nexp = 0;
    endtask

    task automatic launch(bit chain, bit fwd, bit irqen, int madr, int qwc, int tadr);
        cfg_chain = chain; cfg_tag_fwd = fwd; cfg_tag_irq_en = irqen;
        cfg_madr = madr; cfg_qwc = qwc[CW-1:0]; cfg_tadr = tadr;
        cfg_start = 1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done_irq", done_irq, 0);
        check("R1", "tag_err", tag_err, 0);
        check("R1", "fifo_push", fifo_push, 0);
        check("R1", "mem_req", mem_req, 0);
    endtask

    task automatic t_normal();
        clear_run();
        launch(0, 0, 0, 32'h100, 3, 0);
        check("R2", "busy after start", busy, 1);
        wait_idle();
        exp_qw(16); exp_qw(17); exp_qw(18);
        check_log("R2");
        check("R2", "irq pulses", nirq, 1);
        check("R2", "busy at end", busy, 0);
        check("R12", "read requests", nreq, 3);
    endtask

    task automatic t_zero();
        clear_run();
        launch(0, 0, 0, 32'h100, 0, 0);
        wait_idle();
        check("R2", "zero count words", nlog, 0);
        check("R2", "zero count irq", nirq, 1);
    endtask

    task automatic t_chain();
        clear_run();
        launch(1, 0, 0, 0, 0, 32'h000);
        wait_idle();
        exp_qw(1); exp_qw(2);
        exp_qw(4);
        exp_qw(48);
        exp_qw(49);
        exp_qw(35);
        check_log("R4 R5 R6 R7");
        check("R7", "end tag irq", nirq, 1);
        check("R12", "chain requests", nreq, 11);
        check("R6", "no error", tag_err, 0);
    endtask

    task automatic t_fwd_refe();
        clear_run();
        launch(1, 1, 0, 0, 0, 32'h080);
        wait_idle();
        exp_tagfwd(8);
        exp_qw(40);
        check_log("R8 R7");
        check("R7", "refe irq", nirq, 1);
    endtask

    task automatic t_tag_irq();
        clear_run();
        launch(1, 0, 1, 0, 0, 32'h090);
        wait_idle();
        exp_qw(10);
        check_log("R9");
        check("R9", "irq when enabled", nirq, 1);
        clear_run();
        launch(1, 0, 0, 0, 0, 32'h090);
        wait_idle();
        exp_qw(10); exp_qw(12);
        check_log("R9");
        check("R9", "irq when disabled", nirq, 1);
    endtask

    task automatic t_bad_tag();
        clear_run();
        launch(1, 0, 0, 0, 0, 32'h0D0);
        wait_idle();
        check("R10", "err flag", tag_err, 1);
        check("R10", "busy", busy, 0);
        check("R10", "no irq", nirq, 0);
        check("R10", "no words", nlog, 0);
        clear_run();
        launch(0, 0, 0, 32'h100, 0, 0);
        wait_idle();
        check("R10", "err cleared by start", tag_err, 0);
    endtask

    task automatic t_backpressure();
        clear_run();
        drain = 0;
        launch(0, 0, 0, 32'h380, 6, 0);
        repeat (60) @(negedge clk);
        check("R3", "words before stall", nlog, 16);
        check("R3", "busy while stalled", busy, 1);
        check("R3", "no irq while stalled", nirq, 0);
        drain = 1;
        wait_idle();
        for (int k = 56; k < 62; k++) exp_qw(k);
        check_log("R3");
        check("R3", "irq after drain", nirq, 1);
    endtask

    task automatic t_abort();
        clear_run();
        drain = 0;
        launch(0, 0, 0, 32'h380, 6, 0);
        repeat (60) @(negedge clk);
        cfg_start = 0;
        @(negedge clk);
        check("R11", "busy after abort", busy, 0);
        drain = 1;
        repeat (30) @(negedge clk);
        check("R11", "no words after abort", nlog, 16);
        check("R11", "no irq after abort", nirq, 0);
        check("R11", "no error", tag_err, 0);
    endtask

    initial begin
        for (int k = 0; k < 64; k++)
            mem[k] = {mw(k, 3), mw(k, 2), mw(k, 1), mw(k, 0)};
        mem[0]  = {mw(0, 3),  mw(0, 2),  mk_tag(1, 0, 2, 0)};
        mem[3]  = {mw(3, 3),  mw(3, 2),  mk_tag(2, 0, 1, 32'h200)};
        mem[32] = {mw(32, 3), mw(32, 2), mk_tag(3, 0, 1, 32'h300)};
        mem[33] = {mw(33, 3), mw(33, 2), mk_tag(4, 0, 1, 32'h310)};
        mem[34] = {mw(34, 3), mw(34, 2), mk_tag(7, 0, 1, 0)};
        mem[8]  = {mw(8, 3),  mw(8, 2),  mk_tag(0, 0, 1, 32'h280)};
        mem[9]  = {mw(9, 3),  mw(9, 2),  mk_tag(1, 1, 1, 0)};
        mem[11] = {mw(11, 3), mw(11, 2), mk_tag(7, 0, 1, 0)};
        mem[13] = {mw(13, 3), mw(13, 2), mk_tag(5, 0, 1, 0)};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_zero();
        t_chain();
        t_fwd_refe();
        t_tag_irq();
        t_bad_tag();
        t_backpressure();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end
endmodule